// File: doc/BRIEF.md
# Debounced Storage-RAM Clear Controller

This block lets a user wipe the general-purpose storage area of a battery-backed clock chip by holding a pushbutton. The button drives an active-low input. The input has a weak pull-up, so an open pin reads as released. The controller passes the input through a synchronizer. It then times how long the input stays low while main power is valid. Only a continuous hold of the full qualification time, 125 ms by default, counts as a request.

When a request is qualified, the controller takes over the storage RAM write port. It writes all-ones into every storage byte, one byte per clock, in ascending address order. The clock and control registers sit below the storage area in the address map, and the controller never writes them. A busy flag covers the whole fill. A one-cycle done pulse marks its end. The button must be released before another press can start a new fill.

Top module: `store_wipe_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `ram_we` and `done` are low and no fill is pending.
- R2: `clr_n_raw` passes through a two-stage synchronizer whose stages reset to 1 (released), so an input held high never starts a fill.
- R3: A fill is requested only after the synchronized input has been low for HOLD_MS*CLKS_PER_MS consecutive clocks (HOLD_MS = 125 by default) with `power_ok` high. The first write comes on the clock after that count completes.
- R4: A return to high before the hold time is reached clears the hold count to zero, and no fill follows.
- R5: Any clock with `power_ok` low clears the hold count, so a press while main power is absent is never recognized.
- R6: A fill writes exactly 242 bytes, one per clock with `ram_we` high. The addresses run from 14 up to 255 in ascending order, and `ram_wdata` is 8'hFF on every write.
- R7: Addresses 0 to 13 hold the clock and control registers, and the fill never writes them.
- R8: `busy` is high exactly on the clocks where a write occurs. `done` pulses high for one clock, directly after the last write.
- R9: One continuous press starts at most one fill. The synchronized input must go high before a new hold count can begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n_raw | input | 1 | Asynchronous active-low clear button (pulled up externally) |
| power_ok | input | 1 | High while main power is valid |
| ram_we | output | 1 | Storage RAM write enable |
| ram_addr | output | 8 | Storage RAM write address |
| ram_wdata | output | 8 | Storage RAM write data |
| busy | output | 1 | High for the whole fill |
| done | output | 1 | One-clock pulse after the last write |

## Verification
Several properties are checked on every clock: the write pattern is all ones, no write lands in the clock/control region, addresses step up by one through the fill, a fill starts at address 14, the done pulse follows the write to address 255, and a fill only begins two clocks after power was valid. Other behaviour needs the bench's cycle-accurate reference model and its scenarios. These are the exact hold length, discarding a short or power-less press, the need to release between presses, and that the final RAM image holds FF only in the storage bytes.

// File: rtl/swc_pkg.sv
// Package: shared types and default constants for the storage clear controller.
// Assumes an 8-bit address map with clock/control registers below STORE_BASE.
package swc_pkg;
    localparam int DEF_ADDR_W      = 8;
    localparam int DEF_DATA_W      = 8;
    localparam int DEF_STORE_BASE  = 14;
    localparam int DEF_STORE_COUNT = 242;
    localparam int DEF_HOLD_MS     = 125;
    localparam int DEF_CLKS_PER_MS = 1000;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_t;
endpackage

// File: rtl/swc_sync.sv
// Module: multi-stage synchronizer for an asynchronous level input.
// Assumes STAGES >= 1. Every stage resets to RESET_VAL so the output starts inactive.
module swc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RESET_VAL;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // Shift the sample one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RESET_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/swc_hold_qual.sv
// Module: hold-time qualifier. Counts consecutive clocks with the synchronized
// clear input low and power valid. After HOLD_MS milliseconds it emits a
// one-clock fire pulse and locks until the input is seen high again.
// Assumes CLKS_PER_MS >= 1 and HOLD_MS >= 1.
module swc_hold_qual #(
    parameter int CLKS_PER_MS = 1000,
    parameter int HOLD_MS     = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n_s,
    input  logic power_ok,
    output logic fire
);
    localparam int PRE_W = $clog2(CLKS_PER_MS + 1);
    localparam int MS_W  = $clog2(HOLD_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MS - 1);
    localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(HOLD_MS - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [MS_W-1:0]  ms_cnt;
    logic             locked;
    logic             counting;
    logic             pre_wrap;
    logic             hold_met;

    assign counting = !clr_n_s && power_ok && !locked;
    assign pre_wrap = (pre_cnt == PRE_LAST);
    assign hold_met = counting && pre_wrap && (ms_cnt == MS_LAST);

    // Clock-to-millisecond prescaler, cleared whenever the hold is broken.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pre_cnt <= '0;
        else if (!counting || pre_wrap) pre_cnt <= '0;
        else                          pre_cnt <= pre_cnt + 1'b1;
    end

    // Millisecond hold counter, cleared on release, power loss or completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ms_cnt <= '0;
        else if (!counting || hold_met) ms_cnt <= '0;
        else if (pre_wrap)              ms_cnt <= ms_cnt + 1'b1;
    end

    // Fire once per press, and stay locked until the input returns high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire   <= 1'b0;
            locked <= 1'b0;
        end else begin
            fire <= hold_met;
            if (clr_n_s)       locked <= 1'b0;
            else if (hold_met) locked <= 1'b1;
        end
    end
endmodule

// File: rtl/swc_fill_seq.sv
// Module: fill sequencer. On start, it writes all-ones to COUNT consecutive
// addresses beginning at BASE, one per clock, then pulses done.
// Assumes BASE + COUNT <= 2**ADDR_W. A start while running is ignored.
module swc_fill_seq
    import swc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int BASE   = 14,
    parameter int COUNT  = 242
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(BASE + COUNT - 1);

    fill_state_t       state;
    logic [ADDR_W-1:0] addr_q;
    logic              at_last;

    assign at_last = (addr_q == LAST);

    // Sequence state, write address and end-of-fill pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FILL_IDLE;
            addr_q <= FIRST;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                FILL_IDLE: begin
                    if (start) begin
                        state  <= FILL_RUN;
                        addr_q <= FIRST;
                    end
                end
                FILL_RUN: begin
                    if (at_last) begin
                        state <= FILL_IDLE;
                        done  <= 1'b1;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end

    assign we    = (state == FILL_RUN);
    assign busy  = (state == FILL_RUN);
    assign addr  = addr_q;
    assign wdata = '1;
endmodule

// File: rtl/store_wipe_ctrl.sv
// Module: top of the debounced storage clear controller. Synchronizes the
// button, qualifies a long hold under valid power, then fills the storage
// region with all-ones through the RAM write port.
// Assumes clr_n_raw is asynchronous and pulled up outside this block.
module store_wipe_ctrl
    import swc_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int STORE_BASE  = DEF_STORE_BASE,
    parameter int STORE_COUNT = DEF_STORE_COUNT,
    parameter int HOLD_MS     = DEF_HOLD_MS,
    parameter int CLKS_PER_MS = DEF_CLKS_PER_MS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n_raw,
    input  logic              power_ok,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              busy,
    output logic              done
);
    logic clr_n_s;
    logic fire;

    swc_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (clr_n_raw),
        .q     (clr_n_s)
    );

    swc_hold_qual #(
        .CLKS_PER_MS (CLKS_PER_MS),
        .HOLD_MS     (HOLD_MS)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n_s  (clr_n_s),
        .power_ok (power_ok),
        .fire     (fire)
    );

    swc_fill_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BASE   (STORE_BASE),
        .COUNT  (STORE_COUNT)
    ) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .start (fire),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .busy  (busy),
        .done  (done)
    );
endmodule

// File: rtl/store_wipe_chk.sv
// Module: property checker for store_wipe_ctrl, attached with bind.
// Assumes only the top-level ports are visible.
module store_wipe_chk #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int STORE_BASE  = 14,
    parameter int STORE_COUNT = 242
) (
    input logic              clk,
    input logic              rst_n,
    input logic              power_ok,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_wdata,
    input logic              busy,
    input logic              done
);
    localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(STORE_BASE);
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(STORE_BASE + STORE_COUNT - 1);

    // R6
    fill_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_wdata == {DATA_W{1'b1}}));

    // R7
    ctl_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr >= FIRST));

    // R6
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr != LAST) |=> (ram_we && ram_addr == $past(ram_addr) + 1'b1));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && $past(ram_addr) == LAST));

    // R6
    fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ram_addr == FIRST));

    // R5
    power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(power_ok, 2));
endmodule

bind store_wipe_ctrl store_wipe_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STORE_BASE  (STORE_BASE),
    .STORE_COUNT (STORE_COUNT)
) u_store_wipe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .power_ok  (power_ok),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_store_wipe_ctrl.sv
// Bench: cycle-by-cycle behavioural reference model compared on every clock,
// plus a shadow RAM image and per-scenario fill counts.
module test_store_wipe_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 4;
    localparam int HOLD       = 125;
    localparam int HOLD_CYC   = CPM * HOLD;
    localparam int BASE       = 14;
    localparam int CNT        = 242;
    localparam int LAST_A     = BASE + CNT - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n_raw = 1'b1;
    logic       power_ok = 1'b1;
    logic       ram_we;
    logic [7:0] ram_addr;
    logic [7:0] ram_wdata;
    logic       busy;
    logic       done;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    // reference model state
    int m_s0 = 1, m_s1 = 1;
    int m_held = 0;
    bit m_lock = 0, m_fire = 0;
    bit m_busy = 0, m_done = 0;
    int m_addr = BASE;
    int m_fills = 0;

    // shadow RAM observed at the write port
    logic [7:0] shadow [256];
    int dut_fills = 0;

    store_wipe_ctrl #(.CLKS_PER_MS(CPM), .HOLD_MS(HOLD)) i_store_wipe_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_n_raw(clr_n_raw), .power_ok(power_ok),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    end

    // reference model, updated at every rising edge
    always @(posedge clk) begin
        bit nf;
        if (!rst_n) begin
            m_s0 = 1; m_s1 = 1; m_held = 0; m_lock = 0; m_fire = 0;
            m_busy = 0; m_done = 0; m_addr = BASE;
        end else begin
            if (m_busy) begin
                if (m_addr == LAST_A) begin m_busy = 0; m_done = 1; m_fills++; end
                else begin m_addr++; m_done = 0; end
            end else begin
                m_done = 0;
                if (m_fire) begin m_busy = 1; m_addr = BASE; end
            end
            nf = 0;
            if (m_s1 == 1) begin m_held = 0; m_lock = 0; end
            else if (!power_ok || m_lock) m_held = 0;
            else begin
                m_held++;
                if (m_held == HOLD_CYC) begin nf = 1; m_lock = 1; m_held = 0; end
            end
            m_fire = nf;
            m_s1 = m_s0;
            m_s0 = int'(clr_n_raw);
        end
        if (rst_n && ram_we) shadow[ram_addr] = ram_wdata;
        if (rst_n && done) dut_fills++;
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            chk("R8 busy", int'(busy), int'(m_busy));
            chk("R8 we", int'(ram_we), int'(m_busy));
            chk("R8 done", int'(done), int'(m_done));
            if (m_busy) begin
                chk("R6 addr", int'(ram_addr), m_addr);
                chk("R6 wdata", int'(ram_wdata), 255);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int n);
        clr_n_raw = 1'b0; wait_clk(n); clr_n_raw = 1'b1;
    endtask

    task automatic summary;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        wait_clk(4);
        // R1: reset state
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        wait_clk(20);
        // R2: released input never fills
        chk("R2 no fill while released", dut_fills, 0);

        // R4: short presses, including one clock shy of the hold time
        press(300); wait_clk(20);
        press(HOLD_CYC - 1); wait_clk(20);
        chk("R4 short press ignored", dut_fills, 0);

        // R4: brief glitch high breaks the hold
        press(HOLD_CYC - 50); press(0);
        clr_n_raw = 1'b1; wait_clk(1);
        press(HOLD_CYC - 50); wait_clk(20);
        chk("R4 glitch restarts count", dut_fills, 0);

        // R5: press with power absent, then power returns mid-press
        power_ok = 1'b0; press(HOLD_CYC + 100); wait_clk(10);
        chk("R5 no power no fill", dut_fills, 0);
        clr_n_raw = 1'b0; wait_clk(300); power_ok = 1'b1;
        wait_clk(HOLD_CYC - 10); clr_n_raw = 1'b1; wait_clk(20);
        chk("R5 count restarted on power", dut_fills, 0);

        // R3/R9: long hold gives exactly one fill
        press(HOLD_CYC + CNT + 800); wait_clk(300);
        chk("R9 one fill per press", dut_fills, 1);
        chk("R3 model fill count", m_fills, 1);

        // R3: exact hold length fires, second fill after release
        press(HOLD_CYC); wait_clk(CNT + 40);
        chk("R3 exact hold fills", dut_fills, 2);

        // R6/R7: final RAM image
        for (int a = 0; a < 256; a++) begin
            if (a < BASE) chk("R7 ctl byte untouched", int'(shadow[a]), 0);
            else          chk("R6 storage byte FF", int'(shadow[a]), 255);
        end
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule